// File: doc/BRIEF.md
# Serial Programming Entry Controller

This block runs on the host side of a four-wire serial link: a clock, a data-out line, a data-in line and the target's active-low reset pin. It puts an attached microcontroller into its serial programming mode. When `start` arrives it can first give the reset pin a short high pulse, for systems where the clock line was not held low at power-up. It then keeps reset low for a settling window, counted in milliseconds of system clock. After that it shifts out a four-byte programming-enable word.

While the third byte goes out, the controller captures what the target sends back. A target that is in step echoes the second command byte at that point. The controller always finishes all 32 bits. If the echo matches, it raises `ready`. If not, it pulses reset, waits again and reissues the whole word, up to a set number of attempts, and then raises `failed` and goes quiet. When `finish` arrives, the reset pin is released high so the target returns to normal operation.

Top module: `prog_session_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tgt_rst_lvl`, `sck`, `mosi`, `ready` and `failed` are all 0.
- R2: When `PULSE_FIRST`=1, an accepted `start` drives `tgt_rst_lvl` high for exactly `PULSE_CYC` clocks, with `sck` held low throughout.
- R3: After each reset pulse, or after `start` when no pulse is configured, `tgt_rst_lvl` and `sck` stay low for at least `WAIT_MS*MS_CYCLES` clocks before the first rising `sck` edge.
- R4: The enable word `EN_CMD` is sent as 32 bits, most significant bit first. `mosi` changes only while `sck` is low, and each `sck` high phase lasts `SCK_HALF` clocks.
- R5: The controller samples `miso` on each rising `sck` edge. It compares received bits 15..8 (the third byte) with `EN_CMD[23:16]`. On a match it raises `ready`, leaves `failed` low and holds `sck` low.
- R6: All 32 bits of the enable word are clocked out on every attempt, whether or not the echo matches.
- R7: On a mismatch with attempts remaining, the controller gives a new reset pulse and a new settling wait, then reissues the complete enable word.
- R8: After `MAX_TRIES` mismatched attempts, `failed` goes high and `ready` stays low. No further `sck` edges occur and `tgt_rst_lvl` stays low.
- R9: A `finish` pulse while `ready` or `failed` is high drives `tgt_rst_lvl` high and clears both flags. This state holds until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the entry sequence (accepted when idle) |
| finish | input | 1 | End the session and release the target reset |
| miso | input | 1 | Serial data from target |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| tgt_rst_lvl | output | 1 | Level of the target reset pin (0 = held in reset) |
| ready | output | 1 | Target answered the sync check |
| failed | output | 1 | Attempts exhausted without a correct echo |

## Verification
A behavioural target model echoes the second received byte during the third. It can be told to answer with all ones for its first N frames. This gives three patterns: a target in step from the first frame, one that falls into step after two bad frames, and one that never does. The first pattern confirms single-attempt entry, the pulse width and the settle gap. The second separates retry-and-recover from giving up. The third confirms the attempt limit and the silence that follows. Every frame the model captures is compared with the expected enable word, and each frame's bit count is checked, so a truncated or altered frame shows up.

// File: rtl/prog_pkg.sv
package prog_pkg;

    localparam int FRAME_BITS = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE,
        S_SETTLE,
        S_SHIFT,
        S_CHECK,
        S_READY,
        S_FAIL,
        S_DONE
    } sess_state_t;

    // byte the target must send back during the third transfer byte
    function automatic logic [7:0] sync_byte(input logic [FRAME_BITS-1:0] cmd);
        return cmd[23:16];
    endfunction

    // third received byte of a frame (first bit received lands in MSB)
    function automatic logic [7:0] echo_byte(input logic [FRAME_BITS-1:0] rx);
        return rx[15:8];
    endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/prog_shifter.sv
module prog_shifter
    import prog_pkg::*;
#(
    parameter int SCK_HALF = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam int PW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BW = $clog2(FRAME_BITS) + 1;

    logic                  busy;
    logic [PW-1:0]         ph;
    logic [BW-1:0]         bits;
    logic [FRAME_BITS-1:0] sh_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ph      <= '0;
            bits    <= '0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
            sh_tx   <= '0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                ph    <= '0;
                bits  <= '0;
                sck   <= 1'b0;
                mosi  <= tx_word[FRAME_BITS-1];
                sh_tx <= {tx_word[FRAME_BITS-2:0], 1'b0};
            end else if (busy) begin
                if (ph == PW'(SCK_HALF-1)) begin
                    ph <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_word <= {rx_word[FRAME_BITS-2:0], miso};
                    end else begin
                        sck  <= 1'b0;
                        bits <= bits + 1'b1;
                        if (bits == BW'(FRAME_BITS-1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                            mosi <= 1'b0;
                        end else begin
                            mosi  <= sh_tx[FRAME_BITS-1];
                            sh_tx <= {sh_tx[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high"); // R4

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck) else $error("sck high while idle"); // R4
endmodule

// File: rtl/prog_session_ctrl.sv
module prog_session_ctrl
    import prog_pkg::*;
#(
    parameter int                  SCK_HALF    = 8,
    parameter int                  MS_CYCLES   = 200000,
    parameter int                  WAIT_MS     = 20,
    parameter int                  PULSE_CYC   = 64,
    parameter int                  MAX_TRIES   = 8,
    parameter bit                  PULSE_FIRST = 1'b0,
    parameter logic [FRAME_BITS-1:0] EN_CMD    = 32'hAC53_0000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic finish,
    input  logic miso,
    output logic sck,
    output logic mosi,
    output logic tgt_rst_lvl,
    output logic ready,
    output logic failed
);
    localparam int SETTLE_CYC = WAIT_MS * MS_CYCLES;
    localparam int TMAX       = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int TW         = $clog2(TMAX + 1);
    localparam int TRW        = $clog2(MAX_TRIES + 1);

    sess_state_t           state;
    logic [TRW-1:0]        tries;
    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    logic                  tmr_zero;
    logic                  sh_go;
    logic                  sh_done;
    logic [FRAME_BITS-1:0] rx_word;

    prog_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    prog_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk(clk), .rst(rst), .go(sh_go), .tx_word(EN_CMD), .miso(miso),
        .sck(sck), .mosi(mosi), .done(sh_done), .rx_word(rx_word)
    );

    assign sh_go = (state == S_SETTLE) && tmr_zero;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: if (start) begin
                tmr_load = 1'b1;
                tmr_val  = PULSE_FIRST ? TW'(PULSE_CYC-1) : TW'(SETTLE_CYC-1);
            end
            S_PULSE: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC-1);
            end
            S_CHECK: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_CYC-1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            tries       <= '0;
            tgt_rst_lvl <= 1'b0;
            ready       <= 1'b0;
            failed      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state       <= PULSE_FIRST ? S_PULSE : S_SETTLE;
                    tgt_rst_lvl <= PULSE_FIRST;
                end
                S_PULSE: if (tmr_zero) begin
                    tgt_rst_lvl <= 1'b0;
                    state       <= S_SETTLE;
                end
                S_SETTLE: if (tmr_zero) state <= S_SHIFT;
                S_SHIFT:  if (sh_done)  state <= S_CHECK;
                S_CHECK: begin
                    if (echo_byte(rx_word) == sync_byte(EN_CMD)) begin
                        ready <= 1'b1;
                        state <= S_READY;
                    end else if (tries == TRW'(MAX_TRIES-1)) begin
                        failed <= 1'b1;
                        state  <= S_FAIL;
                    end else begin
                        tries       <= tries + 1'b1;
                        tgt_rst_lvl <= 1'b1;
                        state       <= S_PULSE;
                    end
                end
                S_READY, S_FAIL: if (finish) begin
                    ready       <= 1'b0;
                    failed      <= 1'b0;
                    tgt_rst_lvl <= 1'b1;
                    state       <= S_DONE;
                end
                S_DONE: ;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_PULSE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (tgt_rst_lvl && state != S_DONE) |-> !sck) else $error("sck during reset pulse"); // R2

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ready && failed)) else $error("ready and failed together"); // R5

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready |-> !sck) else $error("sck active while ready"); // R5

    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (rst)
        tries < TRW'(MAX_TRIES)) else $error("attempt count overrun"); // R7

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        failed |-> (!sck && !tgt_rst_lvl)) else $error("activity after failure"); // R8

    AST_FINISH_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(finish) && ($past(ready) || $past(failed))) |-> tgt_rst_lvl)
        else $error("reset not released on finish"); // R9
endmodule

// File: tb/tb_prog_session_ctrl.sv
`timescale 1ns/1ps
module tb_prog_session_ctrl;
    localparam int SCK_HALF  = 2;
    localparam int MS_CYCLES = 5;
    localparam int WAIT_MS   = 3;
    localparam int PULSE_CYC = 4;
    localparam int MAX_TRIES = 3;
    localparam logic [31:0] CMD = 32'hAC53_0000;

    logic clk = 0, rst = 1, start = 0, finish = 0, miso = 1;
    logic sck, mosi, tgt_rst_lvl, ready, failed;

    prog_session_ctrl #(
        .SCK_HALF(SCK_HALF), .MS_CYCLES(MS_CYCLES), .WAIT_MS(WAIT_MS),
        .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES), .PULSE_FIRST(1'b1), .EN_CMD(CMD)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .finish(finish), .miso(miso),
        .sck(sck), .mosi(mosi), .tgt_rst_lvl(tgt_rst_lvl), .ready(ready), .failed(failed)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    int  fail_n = 0;
    int  bitcnt = 0, frames = 0, pulses = 0, sck_rises = 0;
    logic [31:0] rxw = 0;
    logic [7:0]  echo = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver side of scoreboard: expected frames
    task automatic expect_frames(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(CMD);
    endtask

    // target model: capture on rising sck, drive on falling sck
    always @(posedge sck) begin
        sck_rises++;
        rxw = {rxw[30:0], mosi};
        bitcnt++;
        if (bitcnt == 32) begin
            // monitor side of scoreboard
            if (exp_q.size() == 0) check(0, "R6 unexpected frame", rxw, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rxw == e, "R4 frame content", rxw, e);
            end
            frames++;
            bitcnt = 0;
        end
    end

    always @(negedge sck) begin
        if (bitcnt == 16) echo = rxw[7:0];
        if (bitcnt >= 16 && bitcnt <= 23)
            miso <= (frames >= fail_n) ? echo[23-bitcnt] : 1'b1;
        else
            miso <= 1'b1;
    end

    always @(posedge tgt_rst_lvl) begin
        pulses++;
        bitcnt = 0;
    end

    // sck high-phase width and mosi stability
    int hi_len = 0;
    logic prev_mosi = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sck) begin
                hi_len++;
                if (hi_len > 1) check(mosi == prev_mosi, "R4 mosi stable while sck high", mosi, prev_mosi);
            end else if (hi_len != 0) begin
                check(hi_len == SCK_HALF, "R4 sck high width", hi_len, SCK_HALF);
                hi_len = 0;
            end
        end
        prev_mosi = mosi;
    end

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check(!tgt_rst_lvl && !sck && !mosi && !ready && !failed, "R1 outputs in reset",
              {tgt_rst_lvl, sck, mosi, ready, failed}, 0);
        rst = 0;
        exp_q.delete();
        bitcnt = 0; frames = 0; pulses = 0; sck_rises = 0;
        @(negedge clk);
        check(!tgt_rst_lvl && !sck && !ready && !failed, "R1 outputs after reset",
              {tgt_rst_lvl, sck, mosi, ready, failed}, 0);
    endtask

    task automatic pulse_start();
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic wait_outcome();
        int k = 0;
        while (!ready && !failed && k < 20000) begin @(negedge clk); k++; end
    endtask

    task automatic do_finish();
        finish = 1; @(negedge clk); finish = 0;
        @(negedge clk);
        check(tgt_rst_lvl == 1, "R9 reset released", tgt_rst_lvl, 1);
        check(!ready && !failed, "R9 flags cleared", {ready, failed}, 0);
        repeat (20) @(negedge clk);
        check(tgt_rst_lvl == 1 && !sck, "R9 released state holds", {tgt_rst_lvl, sck}, 2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int w, g, r0;
        // Test 1: target in step at first frame
        fail_n = 0;
        do_reset();
        expect_frames(1);
        pulse_start();
        w = 0;
        while (tgt_rst_lvl) begin w++; @(negedge clk); end
        check(w == PULSE_CYC, "R2 reset pulse width", w, PULSE_CYC);
        g = 0;
        while (!sck && g < 1000) begin
            if (tgt_rst_lvl) check(0, "R3 reset during settle", 1, 0);
            g++; @(negedge clk);
        end
        check(g >= WAIT_MS*MS_CYCLES, "R3 settle gap", g, WAIT_MS*MS_CYCLES);
        wait_outcome();
        check(ready == 1 && failed == 0, "R5 ready on echo", {ready, failed}, 2);
        check(frames == 1, "R5 single frame", frames, 1);
        check(bitcnt == 0, "R6 whole frame sent", bitcnt, 0);
        r0 = sck_rises;
        repeat (30) @(negedge clk);
        check(sck_rises == r0 && !sck, "R5 sck idle when ready", sck_rises, r0);
        do_finish();
        check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);

        // Test 2: two bad echoes then in step
        fail_n = 2;
        do_reset();
        expect_frames(3);
        pulse_start();
        wait_outcome();
        check(ready == 1 && failed == 0, "R7 recovered after retries", {ready, failed}, 2);
        check(frames == 3, "R7 frame count", frames, 3);
        check(pulses == 3, "R7 reset pulses", pulses, 3);
        check(bitcnt == 0, "R6 frames complete on mismatch", bitcnt, 0);
        check(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);
        do_finish();

        // Test 3: never in step
        fail_n = 1000;
        do_reset();
        expect_frames(MAX_TRIES);
        pulse_start();
        wait_outcome();
        check(failed == 1 && ready == 0, "R8 failed after limit", {ready, failed}, 1);
        check(frames == MAX_TRIES, "R8 attempt count", frames, MAX_TRIES);
        check(bitcnt == 0, "R6 last frame complete", bitcnt, 0);
        r0 = sck_rises;
        repeat (200) @(negedge clk);
        check(sck_rises == r0, "R8 no sck after fail", sck_rises, r0);
        check(tgt_rst_lvl == 0, "R8 reset held low", tgt_rst_lvl, 0);
        check(pulses == MAX_TRIES, "R8 no extra pulse", pulses, MAX_TRIES);
        do_finish();

        report();
    end
endmodule